// File: doc/BRIEF.md
# QoS-Ranked Single-RAM Access Arbiter

This block decides, every cycle, which of eight requesters may use a single-ported RAM. Each requester has its own programmable 2-bit service class. A request with a higher class beats every request with a lower class. Among requests with equal class, the port with the smaller index wins. The block drives a one-hot grant vector, which also serves as the select for the RAM-side multiplexer.

The two lowest classes (0 and 1) must wait one cycle. A request from such a port cannot be granted in the cycle it is first presented. It becomes eligible from the next cycle on. The two upper classes (2 and 3) are eligible at once.

Port 7 keeps two class settings: one for control accesses and one for data accesses. A type bit that travels with port 7's request picks which setting applies. The class settings are written and read through a small address/data configuration port. A write takes effect from the following cycle.

Top module: `qos_sram_arb`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: A grant bit is high only while the same port's request bit is high.
- R3: Among eligible requests, the one with the numerically largest class wins.
- R4: Among eligible requests that share the largest class, the lowest port index wins.
- R5: A port with class 0 or 1 is not granted in the first cycle of its request. That first cycle is the cycle after the request was low, after a grant, or after reset. The port becomes eligible from its second consecutive request cycle.
- R6: A port with class 2 or 3 is eligible in the same cycle it raises its request.
- R7: If some port held its request in the previous cycle without being granted, and still requests, some port is granted.
- R8: After reset, the class settings read back as follows. Addresses 0 and 7 read 3, addresses 1 to 6 read 2, and address 8 reads 3.
- R9: Address k (0..7) holds port k's class. For port 7 this is the control-access setting. Address 8 holds port 7's data-access setting. A write appears on `cfg_rdata_o` and in arbitration from the next cycle.
- R10: Port 7 uses the setting at address 7 when `req7_ctrl_i` is 1 and the setting at address 8 when it is 0.
- R11: The one-cycle wait of R5 is paid again for every new request. This applies after a grant and after the request is withdrawn.
- R12: Addresses 9 to 15 read as 0, and writes to them change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request per port, bit k for port k |
| req7_ctrl_i | input | 1 | Access type of port 7: 1 = control, 0 = data |
| gnt_o | output | 8 | One-hot grant / RAM mux select |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 2 | Class value to write |
| cfg_rdata_o | output | 2 | Class value at `cfg_addr_i` (combinational) |

## Verification
Several properties are checked by assertions on every cycle:
- the grant is one-hot or zero, and every grant belongs to a requesting port;
- a class-0/1 grant is always preceded by an ungranted request cycle;
- no grant ever passes over a better, eligible request;
- no cycle idles while a waited request is pending.

Other behaviour only the bench's scenarios can show: the reset values of the settings, the register map and its ignored addresses, the selection of port 7's setting by access type, and the one-cycle lag before a newly written class changes the winner.

// File: rtl/qos_sram_arb.sv
module qos_sram_arb #(
  parameter int NPORTS = 8,
  parameter int QW     = 2,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] req_i,
  input  logic              req7_ctrl_i,
  output logic [NPORTS-1:0] gnt_o,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [QW-1:0]     cfg_wdata_i,
  output logic [QW-1:0]     cfg_rdata_o
);
  localparam int LAST  = NPORTS - 1;
  localparam int DADDR = NPORTS;
  localparam logic [QW-1:0] QTOP = '1;
  localparam logic [QW-1:0] QMID = QTOP - 1'b1;

  logic [NPORTS-1:0][QW-1:0] qos_q;
  logic [QW-1:0]             qos_dat_q;
  logic [NPORTS-1:0][QW-1:0] eff_q;
  logic [NPORTS-1:0]         waited_q;
  logic [NPORTS-1:0]         elig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORTS; i++)
        qos_q[i] <= (i == 0 || i == LAST) ? QTOP : QMID;
      qos_dat_q <= QTOP;
    end else if (cfg_we_i) begin
      if (int'(cfg_addr_i) < NPORTS) qos_q[cfg_addr_i] <= cfg_wdata_i;
      else if (int'(cfg_addr_i) == DADDR) qos_dat_q <= cfg_wdata_i;
    end
  end

  always_comb begin
    eff_q = qos_q;
    if (!req7_ctrl_i) eff_q[LAST] = qos_dat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) waited_q <= '0;
    else        waited_q <= req_i & ~gnt_o;
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_elig
    assign elig[g] = req_i[g] & (eff_q[g][QW-1] | waited_q[g]);
  end

  always_comb begin
    logic [QW-1:0] best;
    logic          found;
    best  = '0;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (elig[i] && (!found || eff_q[i] > best)) begin
        found = 1'b1;
        best  = eff_q[i];
        gnt_o = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (int'(cfg_addr_i) < NPORTS)        cfg_rdata_o = qos_q[cfg_addr_i];
    else if (int'(cfg_addr_i) == DADDR)   cfg_rdata_o = qos_dat_q;
  end
endmodule

module qos_sram_arb_chk #(
  parameter int NPORTS = 8,
  parameter int QW     = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NPORTS-1:0]         req,
  input logic [NPORTS-1:0]         gnt,
  input logic [NPORTS-1:0][QW-1:0] eff
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_gnt_req_r2: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  p_no_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && |(req & $past(req) & ~$past(gnt))) |-> |gnt);

  for (genvar i = 0; i < NPORTS; i++) begin : g_i
    p_low_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i] && !eff[i][QW-1]) |-> ($past(rst_n) && $past(req[i]) && !$past(gnt[i])));
    for (genvar j = 0; j < NPORTS; j++) begin : g_j
      if (i != j) begin : g_pair
        p_order_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (gnt[j] && req[i] && (eff[i] > eff[j] || (eff[i] == eff[j] && i < j)))
          |-> (!eff[i][QW-1] && !($past(rst_n) && $past(req[i]) && !$past(gnt[i]))));
      end
    end
  end
endmodule

bind qos_sram_arb qos_sram_arb_chk #(.NPORTS(NPORTS), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req_i), .gnt(gnt_o), .eff(eff_q)
);

// File: tb/qos_sram_arb_bench.sv
module qos_sram_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       rctl = 1'b1;
  logic [7:0] gnt;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] wdata = '0;
  logic [1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] mq [9];
  logic [7:0] mw;

  always #10 clk = ~clk;

  qos_sram_arb u_qos_sram_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req7_ctrl_i(rctl), .gnt_o(gnt),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata)
  );

  function automatic logic [1:0] eff(int p, logic c);
    if (p == 7 && !c) return mq[8];
    return mq[p];
  endfunction

  function automatic logic [7:0] exp_gnt(logic [7:0] r, logic c);
    logic [7:0] g = '0;
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (r[i] && (eff(i, c) >= 2 || mw[i]) && int'(eff(i, c)) > best) begin
        best = eff(i, c);
        g = '0;
        g[i] = 1'b1;
      end
    return g;
  endfunction

  function automatic logic [1:0] exp_rd(logic [3:0] a);
    return (a <= 8) ? mq[a] : 2'd0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 9; i++) mq[i] = (i == 0 || i == 7 || i == 8) ? 2'd3 : 2'd2;
    mw = '0;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(logic [7:0] r, logic c, logic w, logic [3:0] a, logic [1:0] d, string tag);
    logic [7:0] eg;
    @(negedge clk);
    req = r; rctl = c; we = w; addr = a; wdata = d;
    #5;
    eg = exp_gnt(r, c);
    check({tag, " grant"}, gnt, eg);
    check({tag, " rdata"}, {6'd0, rdata}, {6'd0, exp_rd(a)});
    @(posedge clk);
    mw = r & ~eg;
    if (w && a <= 8) mq[a] = d;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R8 reset values
    for (int a = 0; a < 9; a++) step('0, 1, 0, 4'(a), 0, "R8");
    // R6 immediate grant of class 2
    step(8'h08, 1, 0, 0, 0, "R6");
    step(8'h00, 1, 0, 0, 0, "R6");
    // R9 write port 2 to class 1, readback next cycle
    step(8'h00, 1, 1, 4'd2, 2'd1, "R9");
    step(8'h00, 1, 0, 4'd2, 0, "R9");
    // R5 first cycle blocked, second granted
    step(8'h04, 1, 0, 0, 0, "R5");
    step(8'h04, 1, 0, 0, 0, "R5");
    // R11 held after grant pays again, withdrawal too
    step(8'h04, 1, 0, 0, 0, "R11");
    step(8'h04, 1, 0, 0, 0, "R11");
    step(8'h00, 1, 0, 0, 0, "R11");
    step(8'h04, 1, 0, 0, 0, "R11");
    step(8'h00, 1, 0, 0, 0, "R11");
    // R4 tie: ports 3 and 5 both class 2
    step(8'h28, 1, 0, 0, 0, "R4");
    // R3 raise port 5 to class 3 beats port 3
    step(8'h00, 1, 1, 4'd5, 2'd3, "R3");
    step(8'h28, 1, 0, 0, 0, "R3");
    // R10 port 7 data setting = 0 while control setting = 3
    step(8'h00, 1, 1, 4'd8, 2'd0, "R10");
    step(8'h80, 0, 0, 4'd8, 0, "R10");
    step(8'h80, 0, 0, 0, 0, "R10");
    step(8'h00, 1, 0, 0, 0, "R10");
    step(8'h80, 1, 0, 0, 0, "R10");
    step(8'h00, 1, 0, 0, 0, "R10");
    // R12 unmapped address
    step(8'h00, 1, 1, 4'd12, 2'd3, "R12");
    step(8'h00, 1, 0, 4'd12, 0, "R12");
    for (int a = 0; a < 9; a++) step('0, 1, 0, 4'(a), 0, "R12");
    // R7 waited low-class requests with class-0 port
    step(8'h00, 1, 1, 4'd1, 2'd0, "R7");
    step(8'h06, 1, 0, 0, 0, "R7");
    step(8'h06, 1, 0, 0, 0, "R7");
    step(8'h06, 1, 0, 0, 0, "R7");
    // random mix: R1 R2 R3 R4 R5
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      logic w;
      w = ($urandom % 8) == 0;
      step(8'($urandom), 1'($urandom), w, 4'($urandom % 10), 2'($urandom), "R1/R3/R4/R5 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule